// File: doc/BRIEF.md
# PWM-Synchronised Conversion Trigger

This block contains a small PWM time base and produces a one-cycle strobe that starts an analog-to-digital conversion at a chosen count inside the PWM period. The time base runs in one of two modes. In the first it counts up from zero to a programmed period and then wraps to zero. In the second it sweeps up from zero to the period and back down again. The strobe is raised when the count reaches a programmed compare value. In the sweeping mode a phase bit also decides whether only the rising half or only the falling half of the sweep may fire it.

A 4-bit postscale field thins out the raw compare events, so that only one in every n+1 of them becomes a strobe. The postscale counter restarts whenever the compare word is written. The time base advances only on cycles where the clock enable is high. It also stops during an idle request, but only when the idle-stop control bit is set. Software programs the block through a narrow write port with three word addresses.

Top module: `pwm_adc_trig`

## Requirements
- R1: In free-running mode (control bit 4 = 0) each advance moves the count up by one. When the count is already at or above the period it goes to 0 instead. `dir_o` reads 0 after every advance in this mode.
- R2: In sweep mode (control bit 4 = 1) the count rises to the period and then falls to 0, changing by one on each advance. `dir_o` is 0 while rising and 1 while falling. The turn happens on the advance that finds the count at the period (rising) or at 0 (falling).
- R3: A raw event occurs on an advance whose current count equals the compare value. The strobe `trig_o` is a single-cycle pulse in the cycle after that advance, and it appears only when the event passes the postscaler.
- R4: In sweep mode the phase bit (compare word bit CNT_W) qualifies the match. When it is 0 the match fires only in the rising phase; when it is 1 it fires only in the falling phase. A count equal to the period is taken as rising, and a count of 0 (below a non-zero period) is taken as falling.
- R5: In free-running mode the phase bit has no effect, and every match is a raw event.
- R6: With postscale field value n (control bits 3:0), the first strobe comes on the (n+1)th raw event after a clear, and the postscale counter returns to zero after each strobe. A new field value applies from the next raw event.
- R7: A write to the compare word clears the postscale counter, even if the value written is unchanged. A raw event in the cycle of that write does not produce a strobe.
- R8: After reset the count is 0, `dir_o` is 0, `trig_o` is 0 and the postscale counter is cleared. The period resets to all ones, and the compare word, control and phase bit reset to 0.
- R9: When the idle-stop bit (control bit 5) is 1 and `idle_req` is high, the count, the direction and the trigger logic hold, and no strobe is produced.
- R10: When the idle-stop bit is 0, `idle_req` has no effect.
- R11: A cycle with `clk_en` low does not advance the count or evaluate the match. A count held across cycles therefore produces no repeated event.
- R12: The write port decodes three addresses: 0 is the period (data bits CNT_W-1:0), 1 is the compare word (compare value in bits CNT_W-1:0 and the phase bit in bit CNT_W), and 2 is the control word. Address 3 is ignored. A write takes effect on the following cycle.
- R13: The compare value may be any count from 0 up to and including the period, and both end points produce events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Time base advance enable |
| idle_req | input | 1 | Idle request from the system |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address |
| wr_data | input | CNT_W+1 | Register write data |
| trig_o | output | 1 | Conversion start pulse |
| count_o | output | CNT_W | Current time base count |
| dir_o | output | 1 | Current direction, 1 = falling |

## Verification
The bench builds the block with a 6-bit count. This keeps the wrap of a reduced period and the sweep back from the reset period of 63 within a few dozen cycles. A short period of 9 (free-running) or 7 (sweep) makes one full period 10 or 14 advances. A window of whole periods therefore contains a known number of matches whatever the starting phase. Postscale ratios of 1, 2, 3 and 4 then yield trigger totals that can be computed by hand. A reference model runs alongside and covers the end-point phases, the idle cases with the stop bit set and clear, and the cycles with the enable low.

// File: rtl/pwm_trig_pkg.sv
`timescale 1ns/1ps
package pwm_trig_pkg;

    localparam int PS_W           = 4;
    localparam int CTRL_MODE_BIT  = 4;
    localparam int CTRL_ISTOP_BIT = 5;

    typedef enum logic {
        MODE_FREE = 1'b0,
        MODE_SWEEP = 1'b1
    } tb_mode_e;

    typedef enum logic [1:0] {
        RA_PERIOD = 2'd0,
        RA_CMP    = 2'd1,
        RA_CTRL   = 2'd2,
        RA_UNUSED = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [PS_W-1:0] ps_ratio;
        tb_mode_e        mode;
        logic            idle_stop;
    } ctrl_t;

    // Phase classification: the period end point is rising, zero is falling,
    // everything in between follows the stored direction.
    function automatic logic phase_is_rising(input logic at_top,
                                             input logic at_zero,
                                             input logic dir_down);
        if (at_top)
            return 1'b1;
        else if (at_zero)
            return 1'b0;
        else
            return ~dir_down;
    endfunction

    function automatic logic match_qualified(input tb_mode_e mode,
                                             input logic     rising,
                                             input logic     want_falling);
        if (mode == MODE_FREE)
            return 1'b1;
        else
            return rising ? ~want_falling : want_falling;
    endfunction

endpackage

// File: rtl/pwm_trig_regs.sv
`timescale 1ns/1ps
module pwm_trig_regs
    import pwm_trig_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int DAT_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DAT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  period_q,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              want_fall_q,
    output ctrl_t             ctrl_q,
    output logic              cmp_wr
);

    reg_addr_e addr;
    assign addr   = reg_addr_e'(wr_addr);
    assign cmp_wr = wr_en && (addr == RA_CMP);

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q    <= '1;
            cmp_q       <= '0;
            want_fall_q <= 1'b0;
            ctrl_q      <= '{ps_ratio: '0, mode: MODE_FREE, idle_stop: 1'b0};
        end else if (wr_en) begin
            unique case (addr)
                RA_PERIOD: period_q <= wr_data[CNT_W-1:0];
                RA_CMP: begin
                    cmp_q       <= wr_data[CNT_W-1:0];
                    want_fall_q <= wr_data[CNT_W];
                end
                RA_CTRL: begin
                    ctrl_q.ps_ratio  <= wr_data[PS_W-1:0];
                    ctrl_q.mode      <= tb_mode_e'(wr_data[CTRL_MODE_BIT]);
                    ctrl_q.idle_stop <= wr_data[CTRL_ISTOP_BIT];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pwm_trig_timebase.sv
`timescale 1ns/1ps
module pwm_trig_timebase
    import pwm_trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  tb_mode_e         mode,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_down,
    output logic             rising
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic at_top, at_zero;
    assign at_top  = (cnt == period);
    assign at_zero = (cnt == '0);
    assign rising  = phase_is_rising(at_top, at_zero, dir_down);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            dir_down <= 1'b0;
        end else if (adv) begin
            if (mode == MODE_FREE) begin
                dir_down <= 1'b0;
                cnt      <= (cnt >= period) ? '0 : cnt + ONE;
            end else if (!dir_down) begin
                if (cnt >= period) begin
                    dir_down <= 1'b1;
                    cnt      <= at_zero ? '0 : cnt - ONE;
                end else begin
                    cnt <= cnt + ONE;
                end
            end else begin
                if (at_zero) begin
                    dir_down <= 1'b0;
                    cnt      <= (period == '0) ? '0 : ONE;
                end else begin
                    cnt <= cnt - ONE;
                end
            end
        end
    end

endmodule

// File: rtl/pwm_trig_event.sv
`timescale 1ns/1ps
module pwm_trig_event
    import pwm_trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             want_fall,
    input  logic             rising,
    input  tb_mode_e         mode,
    input  logic [PS_W-1:0]  ps_ratio,
    input  logic             cmp_wr,
    output logic             trig,
    output logic [PS_W-1:0]  ps_cnt
);

    logic raw_evt, fire;

    assign raw_evt = adv && (cnt == cmp) && match_qualified(mode, rising, want_fall);
    assign fire    = raw_evt && !cmp_wr && (ps_cnt >= ps_ratio);

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_cnt <= '0;
            trig   <= 1'b0;
        end else begin
            trig <= fire;
            if (cmp_wr)
                ps_cnt <= '0;
            else if (raw_evt)
                ps_cnt <= fire ? '0 : ps_cnt + PS_W'(1);
        end
    end

endmodule

// File: rtl/pwm_adc_trig.sv
`timescale 1ns/1ps
module pwm_adc_trig
    import pwm_trig_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int DAT_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en,
    input  logic             idle_req,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [DAT_W-1:0] wr_data,
    output logic             trig_o,
    output logic [CNT_W-1:0] count_o,
    output logic             dir_o
);

    logic [CNT_W-1:0] period_q, cmp_q;
    logic             want_fall_q, cmp_wr, adv, rising;
    ctrl_t            ctrl_q;
    logic [PS_W-1:0]  ps_cnt;

    assign adv = clk_en && !(idle_req && ctrl_q.idle_stop);

    pwm_trig_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .period_q    (period_q),
        .cmp_q       (cmp_q),
        .want_fall_q (want_fall_q),
        .ctrl_q      (ctrl_q),
        .cmp_wr      (cmp_wr)
    );

    pwm_trig_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .mode     (ctrl_q.mode),
        .period   (period_q),
        .cnt      (count_o),
        .dir_down (dir_o),
        .rising   (rising)
    );

    pwm_trig_event #(.CNT_W(CNT_W)) u_evt (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .cnt       (count_o),
        .cmp       (cmp_q),
        .want_fall (want_fall_q),
        .rising    (rising),
        .mode      (ctrl_q.mode),
        .ps_ratio  (ctrl_q.ps_ratio),
        .cmp_wr    (cmp_wr),
        .trig      (trig_o),
        .ps_cnt    (ps_cnt)
    );

endmodule

// File: rtl/pwm_adc_trig_chk.sv
`timescale 1ns/1ps
module pwm_adc_trig_chk
    import pwm_trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             clk_en,
    input logic             idle_req,
    input logic             idle_stop,
    input tb_mode_e         mode,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] cmp_q,
    input logic [CNT_W-1:0] period_q,
    input logic             want_fall_q,
    input logic             dir_o,
    input logic             trig_o,
    input logic             cmp_wr,
    input logic [PS_W-1:0]  ps_cnt
);

    // R11: no advance means no movement and no strobe
    a_r11_hold_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(count_o) && $stable(dir_o) && !trig_o);

    // R9: idle with the stop bit set freezes everything
    a_r9_idle_freeze: assert property (@(posedge clk) disable iff (rst)
        (idle_req && idle_stop) |=> $stable(count_o) && $stable(dir_o) && !trig_o);

    // R3: a strobe follows an advance whose count equalled the compare value
    a_r3_strobe_on_match: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> $past(clk_en) && ($past(count_o) == $past(cmp_q)));

    // R7: compare write clears the postscaler and blocks the strobe
    a_r7_cmp_write_clears: assert property (@(posedge clk) disable iff (rst)
        cmp_wr |=> (ps_cnt == '0) && !trig_o);

    // R6: the postscaler restarts after every strobe
    a_r6_restart_after_strobe: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> (ps_cnt == '0));

    // R4: mid-sweep strobes happen only in the selected phase
    a_r4_phase_qualified: assert property (@(posedge clk) disable iff (rst)
        (trig_o && ($past(mode) == MODE_SWEEP) && ($past(count_o) != $past(period_q))
         && ($past(count_o) != '0)) |-> ($past(dir_o) == $past(want_fall_q)));

    // R1: free-running advances leave the direction at rising
    a_r1_free_rising: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !(idle_req && idle_stop) && mode == MODE_FREE) |=> !dir_o);

endmodule

bind pwm_adc_trig pwm_adc_trig_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clk_en      (clk_en),
    .idle_req    (idle_req),
    .idle_stop   (ctrl_q.idle_stop),
    .mode        (ctrl_q.mode),
    .count_o     (count_o),
    .cmp_q       (cmp_q),
    .period_q    (period_q),
    .want_fall_q (want_fall_q),
    .dir_o       (dir_o),
    .trig_o      (trig_o),
    .cmp_wr      (cmp_wr),
    .ps_cnt      (ps_cnt)
);

// File: tb/pwm_adc_trig_tb.sv
`timescale 1ns/1ps
module pwm_adc_trig_tb;

    localparam int CNT_W = 6;
    localparam int DAT_W = CNT_W + 1;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             clk_en = 1'b0;
    logic             idle_req = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = 2'd0;
    logic [DAT_W-1:0] wr_data = '0;
    logic             trig_o;
    logic [CNT_W-1:0] count_o;
    logic             dir_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R8";

    always #2.5 clk = ~clk;

    pwm_adc_trig #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .idle_req(idle_req),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .trig_o(trig_o), .count_o(count_o), .dir_o(dir_o)
    );

    // reference model state
    int m_cnt, m_dir, m_per, m_cmp, m_fall, m_ps, m_psr, m_sweep, m_istop, m_trig;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_dir = 0; m_per = MAXC; m_cmp = 0; m_fall = 0;
            m_ps = 0; m_psr = 0; m_sweep = 0; m_istop = 0; m_trig = 0;
        end else begin
            int adv, up, match, fire;
            adv  = clk_en && !(idle_req && m_istop);
            fire = 0;
            if (adv) begin
                if (m_cnt == m_per) up = 1;
                else if (m_cnt == 0) up = 0;
                else up = !m_dir;
                match = (m_cnt == m_cmp) && (!m_sweep || (up ? !m_fall : m_fall));
                if (wr_en && wr_addr == 2'd1) m_ps = 0;
                else if (match) begin
                    if (m_ps >= m_psr) begin m_ps = 0; fire = 1; end
                    else m_ps = m_ps + 1;
                end
                if (!m_sweep) begin
                    m_dir = 0;
                    m_cnt = (m_cnt >= m_per) ? 0 : m_cnt + 1;
                end else if (m_dir == 0) begin
                    if (m_cnt >= m_per) begin m_dir = 1; m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
                    else m_cnt = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin m_dir = 0; m_cnt = (m_per == 0) ? 0 : 1; end
                    else m_cnt = m_cnt - 1;
                end
            end else if (wr_en && wr_addr == 2'd1) begin
                m_ps = 0;
            end
            m_trig = fire;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_per = int'(wr_data[CNT_W-1:0]);
                    2'd1: begin m_cmp = int'(wr_data[CNT_W-1:0]); m_fall = wr_data[CNT_W]; end
                    2'd2: begin m_psr = int'(wr_data[3:0]); m_sweep = wr_data[4]; m_istop = wr_data[5]; end
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (int'(count_o) != m_cnt || int'(dir_o) != m_dir || int'(trig_o) != m_trig) begin
                errors++;
                $display("FAIL %s: cnt/dir/trig actual %0d/%0d/%0d expected %0d/%0d/%0d",
                         tag, count_o, dir_o, trig_o, m_cnt, m_dir, m_trig);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(addr); wr_data = DAT_W'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // run n clocks after a write edge and count strobes (includes the sample after the write edge)
    task automatic count_trigs(input int n, output int hits);
        hits = int'(trig_o);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hits += int'(trig_o);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int h, c0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        check("R8", int'(count_o), 0);
        check("R8", int'(dir_o), 0);
        check("R8", int'(trig_o), 0);
        clk_en = 1'b1;

        // R1 R12 free-running period 9, compare 4, ratio 1:1
        tag = "R1";
        wr(0, 9); wr(2, 0); idle(70);
        wr(1, 4);
        count_trigs(100, h);
        check("R3", h, 10);

        // R6 ratio 1:2 and 1:3
        tag = "R6";
        wr(2, 1); wr(1, 4);
        count_trigs(100, h);
        check("R6", h, 5);
        wr(2, 2); wr(1, 4);
        count_trigs(100, h);
        check("R6", h, 3);

        // R7 rewrite with same value clears the postscaler (ratio 1:4)
        tag = "R7";
        wr(2, 3); wr(1, 4);
        count_trigs(60, h);
        check("R7", h, 1);
        wr(1, 4);
        count_trigs(20, h);
        check("R7", h, 0);

        // R5 phase bit ignored in free-running mode
        tag = "R5";
        wr(2, 0); wr(1, (1 << CNT_W) | 4);
        count_trigs(100, h);
        check("R5", h, 10);

        // R12 address 3 ignored
        wr(3, 2); idle(5);
        wr(1, 4);
        count_trigs(100, h);
        check("R12", h, 10);

        // R2 R4 sweep, period 7
        tag = "R2";
        wr(0, 7); wr(2, 16); idle(80);
        wr(1, 3);
        count_trigs(140, h);
        check("R4", h, 10);
        wr(1, (1 << CNT_W) | 3);
        count_trigs(140, h);
        check("R4", h, 10);
        // R13 end points
        tag = "R13";
        wr(1, 7);
        count_trigs(140, h);
        check("R13", h, 10);
        wr(1, (1 << CNT_W) | 7);
        count_trigs(140, h);
        check("R13", h, 0);
        wr(1, (1 << CNT_W) | 0);
        count_trigs(140, h);
        check("R13", h, 10);
        wr(1, 0);
        count_trigs(140, h);
        check("R13", h, 0);

        // R9 idle with stop bit set
        tag = "R9";
        wr(2, 32 | 16); wr(1, 3);
        idle_req = 1'b1;
        @(negedge clk); c0 = int'(count_o);
        count_trigs(50, h);
        check("R9", h, 0);
        check("R9", int'(count_o), c0);
        idle_req = 1'b0;
        idle(3);
        check("R9", int'(count_o) != c0, 1);

        // R10 idle without stop bit
        tag = "R10";
        wr(2, 16); wr(1, 3);
        idle_req = 1'b1;
        count_trigs(140, h);
        check("R10", h, 10);
        idle_req = 1'b0;

        // R11 enable low holds the count at the match
        tag = "R11";
        wr(2, 0); wr(0, 9); idle(30);
        wr(1, 4);
        while (count_o != 4) @(negedge clk);
        clk_en = 1'b0;
        count_trigs(30, h);
        check("R11", h, 0);
        check("R11", int'(count_o), 4);
        clk_en = 1'b1;
        count_trigs(5, h);
        check("R11", h, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule